// File: doc/BRIEF.md
# Framed Pattern Scrambler with Serializer and Differential Encoder

This block is the transmit bit path that follows frame assembly in a DBPSK link. Bytes arrive on a valid/ready interface. Each byte carries a flag that marks it as a preamble byte. Preamble bytes pass through unchanged. Every other byte is XORed with one byte of a fixed 32-bit pseudo-noise word. The byte index restarts at every frame, and the word repeats every four codeword bytes.

The scrambled bytes are then shifted out one bit per clock, most significant bit first. The serial stream goes through a differential encoder whose registered output is fed back, so the phase ambiguity of a non-coherent demodulator does no harm.

A matching receive-side byte descrambler sits in the same top module. It applies the same word, with the same restart rule driven by its own preamble flag, and returns the original codeword bytes one clock later.

Top module: `pnx_scramble_dbpsk`

## Requirements
- R1: While reset is held and right after it, `in_ready` is 1, `tx_bit_valid` is 0, `tx_bit` is 0 and `rx_out_valid` is 0.
- R2: The pattern word P[31:0] comes from a 5-bit register r seeded 11111. For i from 31 down to 1, P[i] = r[4], and then r becomes {r[3:0], r[4]^r[2]}. P[0] is 0. Pattern byte j is P[31-8j : 24-8j]. The n-th codeword byte after a preamble (n from 0) is sent as the byte XOR pattern byte (n mod 4).
- R3: A byte accepted with `in_pre`=1 is sent unscrambled, and it resets the pattern index so that the next codeword byte uses pattern byte 0. This holds even when the previous codeword length was not a multiple of 4.
- R4: Each accepted byte produces exactly 8 valid output bits on 8 consecutive cycles, most significant bit first.
- R5: `in_ready` is 1 exactly when at most one bit of the current byte is still to be shifted out. When bytes are always available, the serial stream has no gaps and `in_ready` is high one cycle in eight.
- R6: Each valid output bit equals the scrambled bit XOR the previous `tx_bit`. The encoder state starts at 0.
- R7: While `tx_bit_valid` is 0, `tx_bit` keeps its last value.
- R8: The first encoded bit of a byte accepted at clock edge E is on `tx_bit` after edge E+1.
- R9: A byte presented with `rx_valid`=1 appears on `rx_out_byte`, with `rx_out_valid`=1, after the next edge. It is unchanged if `rx_pre`=1 and otherwise XORed with the pattern byte chosen by the R2/R3 index rule. As a result, feeding the transmitted bytes back through it returns the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte is present |
| in_ready | output | 1 | Serializer can take a byte this cycle |
| in_pre | input | 1 | Input byte is a preamble byte (not scrambled, restarts pattern) |
| in_byte | input | 8 | Input byte |
| tx_bit | output | 1 | Differentially encoded serial bit |
| tx_bit_valid | output | 1 | `tx_bit` carries a new bit this cycle |
| rx_valid | input | 1 | Received byte is present |
| rx_pre | input | 1 | Received byte is a preamble byte |
| rx_byte | input | 8 | Received scrambled byte |
| rx_out_valid | output | 1 | Descrambled byte is valid |
| rx_out_byte | output | 8 | Descrambled byte |

## Verification
An input byte accepted at edge E loads the serializer at E. Its eight encoded bits appear after edges E+1 through E+8, and `in_ready` comes back high after edge E+7. The descrambler result is due one edge after the received byte. The bench drives inputs and compares every output at the falling edge. A reference model keeps a queue of pending scrambled bits and is advanced once per rising edge, so each expectation is sampled in the cycle in which its result is due. The model also recovers each scrambled bit from consecutive `tx_bit` values, which lets the pattern and restart rules be checked apart from the encoder.

// File: rtl/pnx_pkg.sv
package pnx_pkg;
    localparam int BYTE_W    = 8;
    localparam int PAT_BYTES = 4;
    localparam int PAT_W     = BYTE_W * PAT_BYTES;
    localparam int LFSR_LEN  = 5;
    localparam int IDX_W     = $clog2(PAT_BYTES);
    localparam int CNT_W     = $clog2(BYTE_W + 1);

    // 31 LFSR bits (x^5+x^3+1, all-ones seed) followed by a trailing 0
    function automatic logic [PAT_W-1:0] pnx_pattern();
        logic [LFSR_LEN-1:0] r;
        logic [PAT_W-1:0]    p;
        r = '1;
        p = '0;
        for (int i = PAT_W - 1; i >= 1; i--) begin
            p[i] = r[LFSR_LEN-1];
            r = {r[LFSR_LEN-2:0], r[LFSR_LEN-1] ^ r[LFSR_LEN-3]};
        end
        return p;
    endfunction

    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } mix_st_t;

    typedef struct packed {
        logic [BYTE_W-1:0] sr;
        logic [CNT_W-1:0]  cnt;
    } ser_st_t;

    typedef struct packed {
        logic enc;
        logic vld;
    } enc_st_t;

    typedef struct packed {
        logic              vld;
        logic [BYTE_W-1:0] data;
    } rxo_st_t;
endpackage

// File: rtl/pnx_byte_mixer.sv
module pnx_byte_mixer
    import pnx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              pre,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    localparam logic [PAT_W-1:0] PAT = pnx_pattern();

    logic [BYTE_W-1:0] pat_byte [PAT_BYTES];

    for (genvar g = 0; g < PAT_BYTES; g++) begin : g_pat
        assign pat_byte[g] = PAT[PAT_W-1-g*BYTE_W -: BYTE_W];
    end

    mix_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        dout = pre ? din : (din ^ pat_byte[st_q.idx]);
        if (take) begin
            if (pre || (st_q.idx == IDX_W'(PAT_BYTES - 1)))
                st_d.idx = '0;
            else
                st_d.idx = st_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // preamble restarts the pattern at byte 0
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pre) |=> (st_q.idx == '0));

    // pattern repeats after its last byte
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !pre && st_q.idx == IDX_W'(PAT_BYTES - 1)) |=> (st_q.idx == '0));
endmodule

// File: rtl/pnx_serializer.sv
module pnx_serializer
    import pnx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    output logic              load_ready,
    input  logic [BYTE_W-1:0] load_data,
    output logic              bit_out,
    output logic              bit_valid
);
    ser_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        load_ready = (st_q.cnt <= CNT_W'(1));
        bit_out    = st_q.sr[BYTE_W-1];
        bit_valid  = (st_q.cnt != '0);
        if (load_valid && load_ready) begin
            st_d.sr  = load_data;
            st_d.cnt = CNT_W'(BYTE_W);
        end else if (st_q.cnt != '0) begin
            st_d.sr  = {st_q.sr[BYTE_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_load_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && load_ready) |=> (st_q.cnt == CNT_W'(BYTE_W)));

    p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt > CNT_W'(1)) |=> bit_valid);
endmodule

// File: rtl/pnx_diff_enc.sv
module pnx_diff_enc
    import pnx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_in_valid,
    output logic enc_out,
    output logic enc_valid
);
    enc_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = bit_in_valid;
        if (bit_in_valid) st_d.enc = bit_in ^ st_q.enc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enc_out   = st_q.enc;
    assign enc_valid = st_q.vld;

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_in_valid |=> $stable(enc_out));
endmodule

// File: rtl/pnx_scramble_dbpsk.sv
module pnx_scramble_dbpsk
    import pnx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_pre,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              tx_bit,
    output logic              tx_bit_valid,
    input  logic              rx_valid,
    input  logic              rx_pre,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              rx_out_valid,
    output logic [BYTE_W-1:0] rx_out_byte
);
    logic [BYTE_W-1:0] tx_mixed;
    logic [BYTE_W-1:0] rx_mixed;
    logic              ser_bit;
    logic              ser_vld;
    logic              tx_take;

    assign tx_take = in_valid && in_ready;

    pnx_byte_mixer u_tx_mix (
        .clk  (clk),
        .rst_n(rst_n),
        .take (tx_take),
        .pre  (in_pre),
        .din  (in_byte),
        .dout (tx_mixed)
    );

    pnx_serializer u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_valid(in_valid),
        .load_ready(in_ready),
        .load_data (tx_mixed),
        .bit_out   (ser_bit),
        .bit_valid (ser_vld)
    );

    pnx_diff_enc u_enc (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (ser_bit),
        .bit_in_valid(ser_vld),
        .enc_out     (tx_bit),
        .enc_valid   (tx_bit_valid)
    );

    pnx_byte_mixer u_rx_mix (
        .clk  (clk),
        .rst_n(rst_n),
        .take (rx_valid),
        .pre  (rx_pre),
        .din  (rx_byte),
        .dout (rx_mixed)
    );

    rxo_st_t rxo_d, rxo_q;

    always_comb begin
        rxo_d     = rxo_q;
        rxo_d.vld = rx_valid;
        if (rx_valid) rxo_d.data = rx_mixed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rxo_q <= '0;
        else        rxo_q <= rxo_d;
    end

    assign rx_out_valid = rxo_q.vld;
    assign rx_out_byte  = rxo_q.data;

    p_rx_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> rx_out_valid);

    p_first_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> ##1 tx_bit_valid);
endmodule

// File: tb/tb_pnx_scramble_dbpsk.sv
module tb_pnx_scramble_dbpsk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic       in_pre = 1'b0;
    logic [7:0] in_byte = '0;
    logic       tx_bit;
    logic       tx_bit_valid;
    logic       rx_valid = 1'b0;
    logic       rx_pre = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_out_valid;
    logic [7:0] rx_out_byte;

    always #4 clk = ~clk;

    pnx_scramble_dbpsk dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_pre(in_pre), .in_byte(in_byte),
        .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid),
        .rx_valid(rx_valid), .rx_pre(rx_pre), .rx_byte(rx_byte),
        .rx_out_valid(rx_out_valid), .rx_out_byte(rx_out_byte)
    );

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    logic [31:0] pat;
    bit   q_b[$];
    bit   q_p[$];
    logic [7:0] st_byte[$];
    bit   st_pre[$];
    logic m_enc = 1'b0;
    logic m_encv = 1'b0;
    logic last_scr = 1'b0;
    bit   last_pre = 1'b0;
    logic prev_obs = 1'b0;
    int   m_idx = 0;
    logic m_rxv = 1'b0;
    logic [7:0] m_rxb = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycles);
        end
    endtask

    task automatic add_frame(input int n, input int kind);
        for (int i = 0; i < 4; i++) begin
            st_byte.push_back(8'hC3 ^ 8'(i * 17));
            st_pre.push_back(1'b1);
        end
        for (int i = 0; i < n; i++) begin
            case (kind)
                0: st_byte.push_back(8'h00);
                1: st_byte.push_back(8'(i));
                2: st_byte.push_back(8'hFF);
                default: st_byte.push_back(8'(i * 37 + 5));
            endcase
            st_pre.push_back(1'b0);
        end
    endtask

    task automatic step(input bit gaps);
        bit   acc;
        logic [7:0] scr;
        // checks on current outputs
        chk(in_ready == (q_b.size() <= 1), "R5 in_ready", int'(in_ready), int'(q_b.size() <= 1));
        chk(tx_bit_valid == m_encv, "R4/R8 tx_bit_valid", int'(tx_bit_valid), int'(m_encv));
        if (m_encv) begin
            chk(tx_bit == m_enc, "R6 tx_bit", int'(tx_bit), int'(m_enc));
            chk((tx_bit ^ prev_obs) == last_scr, last_pre ? "R3 preamble bit" : "R2 scrambled bit",
                int'(tx_bit ^ prev_obs), int'(last_scr));
        end else begin
            chk(tx_bit == m_enc, "R7 hold", int'(tx_bit), int'(m_enc));
        end
        chk(rx_out_valid == m_rxv, "R9 rx_out_valid", int'(rx_out_valid), int'(m_rxv));
        if (m_rxv) chk(rx_out_byte == m_rxb, "R9 round trip", int'(rx_out_byte), int'(m_rxb));
        prev_obs = tx_bit;

        // drive inputs
        in_valid = (st_byte.size() > 0) && (!gaps || ($urandom % 4 != 0));
        in_pre   = (st_byte.size() > 0) ? st_pre[0] : 1'b0;
        in_byte  = (st_byte.size() > 0) ? st_byte[0] : 8'h00;

        // model for the coming edge
        acc = in_valid && (q_b.size() <= 1);
        if (q_b.size() > 0) begin
            last_scr = q_b.pop_front();
            last_pre = q_p.pop_front();
            m_enc  = m_enc ^ last_scr;
            m_encv = 1'b1;
        end else begin
            m_encv = 1'b0;
        end
        if (acc) begin
            scr = in_pre ? in_byte : (in_byte ^ pat[31 - 8*m_idx -: 8]);
            m_idx = in_pre ? 0 : (m_idx + 1) % 4;
            for (int b = 7; b >= 0; b--) begin
                q_b.push_back(scr[b]);
                q_p.push_back(in_pre);
            end
            rx_valid = 1'b1;
            rx_pre   = in_pre;
            rx_byte  = scr;
            m_rxv    = 1'b1;
            m_rxb    = in_byte;
            void'(st_byte.pop_front());
            void'(st_pre.pop_front());
        end else begin
            rx_valid = 1'b0;
            rx_pre   = 1'b0;
            rx_byte  = 8'h5A;
            m_rxv    = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        cycles++;
    endtask

    initial begin : watchdog
        #(8 * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [4:0] r;
        r = 5'h1f;
        pat = '0;
        for (int i = 31; i >= 1; i--) begin
            pat[i] = r[4];
            r = {r[3:0], r[4] ^ r[2]};
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(tx_bit_valid == 1'b0, "R1 tx_bit_valid", int'(tx_bit_valid), 0);
        chk(tx_bit == 1'b0, "R1 tx_bit", int'(tx_bit), 0);
        chk(rx_out_valid == 1'b0, "R1 rx_out_valid", int'(rx_out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && tx_bit_valid == 1'b0, "R1 after reset",
            int'({in_ready, tx_bit_valid}), 2);

        // continuous stream: zero bytes expose the pattern (R2), no gaps (R5)
        add_frame(8, 0);
        add_frame(10, 1);
        while (st_byte.size() > 0) step(1'b0);
        // short codeword of 5 bytes, then a new frame restarts the index (R3)
        add_frame(5, 2);
        add_frame(12, 3);
        add_frame(3, 0);
        while (st_byte.size() > 0) step(1'b1);
        // drain and idle: hold check (R7)
        repeat (20) step(1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule